// File: doc/BRIEF.md
# Multi-channel interrupt source aggregator

This block collects the interrupt requests of eight serial channels into one place so that a host can find which channel needs service, and why, with a few register reads. Each channel offers four raw request flags (line status, received data or receive time-out, transmitter empty, modem status), each gated by that channel's own enable bits. The block picks the most urgent enabled request per channel and encodes it as a 3-bit code. A device-level timer event is also routed in, but only to channel 0. The block raises a wake-up flag when the device leaves a state in which every channel was asleep.

The host reads a window of four byte-wide registers through a simple read port: a strobe, an address and a registered data output. Offset 0 is a pending summary with one bit per channel. Offsets 1 to 3 together hold a 24-bit vector of per-channel codes. A single active-high interrupt line tells the host that something is pending. A channel's pending state follows its request inputs, so it goes away when the channel's own status reads remove the cause. The wake-up flag is held until the host reads the summary register.

Top module: `irq_gather`

## Requirements
- R1: After reset, all four registers read 0x00, the interrupt output is low and the read data output is 0x00.
- R2: Summary bit N (offset 0) is 1 exactly when channel N has at least one enabled active request (channel 0 also counts an enabled timer event); it returns to 0 once the requests drop.
- R3: Channel N's code sits in bits [3N+2:3N] of a 24-bit vector; offset 1 returns vector bits 7:0, offset 2 bits 15:8 and offset 3 bits 23:16.
- R4: Request flag k of channel N is input bit 4N+k (k=0 line status, 1 received data, 2 transmitter empty, 3 modem status); with several active the code is the most urgent one: line status = 1, received data = 2, transmitter empty = 3, modem status = 4, timer = 7, none = 0.
- R5: A request whose enable bit (same position as the request bit) is 0 is ignored: it sets no summary bit and no code.
- R6: The timer event, when its enable is 1, appears only on channel 0 as code 7, below every other channel 0 source; no other channel ever shows code 7, and with its enable at 0 the timer event is ignored.
- R7: The wake-up flag sets one clock after the sleep inputs go from all eight high to not all high, provided the wake enable is 1; it does not set if fewer than eight channels were asleep or the wake enable is 0.
- R8: A read of offset 0 clears the wake-up flag; reads of offsets 1 to 3 leave it set.
- R9: The interrupt output is high whenever any summary bit or the wake-up flag is set, and low otherwise.
- R10: Read data updates at the clock edge that samples the read strobe, carrying the register value held before that edge, and holds its value while no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_src_i | input | 32 | Raw request flags, four per channel (bit 4N+k) |
| chan_en_i | input | 32 | Per-request enables, same layout as chan_src_i |
| tmr_evt_i | input | 1 | Timer time-out event (level) |
| tmr_en_i | input | 1 | Timer interrupt enable |
| sleep_i | input | 8 | Per-channel sleep status |
| wake_en_i | input | 1 | Wake-up interrupt enable |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 2 | Register offset within the window |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt request, active high |

## Verification
Every cycle the assertions check that each channel's summary bit agrees with its code field, that a present enabled line-status request yields code 1 on the next cycle, that code 7 never shows on channels 1 to 7, that the wake-up flag only rises after a full-sleep cycle and drops after a summary read with wake-up disabled, and that read data holds without a strobe and returns the prior summary after a summary read. The exact packing of codes across the three locator bytes, the full priority ladder as sources are removed one by one, the timer's masking and the partial-sleep and disabled-wake cases are shown only by the bench's scenarios, which compare every read against values computed from the requirements.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
    localparam int CODE_W = 3;
    localparam int SRC_N  = 4;

    // request bit positions inside a channel's group of four
    localparam int B_LINE = 0;
    localparam int B_RXD  = 1;
    localparam int B_TXE  = 2;
    localparam int B_MDM  = 3;

    typedef enum logic [CODE_W-1:0] {
        SRC_NONE = 3'd0,
        SRC_LINE = 3'd1,
        SRC_RXD  = 3'd2,
        SRC_TXE  = 3'd3,
        SRC_MDM  = 3'd4,
        SRC_TMR  = 3'd7
    } src_code_e;
endpackage

// File: rtl/irq_chan_enc.sv
module irq_chan_enc
    import irq_gather_pkg::*;
#(
    parameter bit HAS_TIMER = 1'b0
) (
    input  logic [SRC_N-1:0]  src_i,
    input  logic [SRC_N-1:0]  en_i,
    input  logic              tmr_i,
    output logic [CODE_W-1:0] code_o,
    output logic              req_o
);
    logic [SRC_N-1:0] act_w;

    always_comb begin
        act_w = src_i & en_i;
        if (act_w[B_LINE])              code_o = SRC_LINE;
        else if (act_w[B_RXD])          code_o = SRC_RXD;
        else if (act_w[B_TXE])          code_o = SRC_TXE;
        else if (act_w[B_MDM])          code_o = SRC_MDM;
        else if (HAS_TIMER && tmr_i)    code_o = SRC_TMR;
        else                            code_o = SRC_NONE;
        req_o = (code_o != SRC_NONE);
    end
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sleep_i,
    input  logic           wake_en_i,
    input  logic           clr_i,
    output logic           wake_o
);
    typedef struct packed {
        logic all_slp;
        logic wake;
    } wk_t;

    wk_t  st_d, st_q;
    logic evt_w;

    always_comb begin
        st_d          = st_q;
        evt_w         = st_q.all_slp & ~(&sleep_i);
        st_d.all_slp  = &sleep_i;
        st_d.wake     = (st_q.wake & ~clr_i) | (evt_w & wake_en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wake_o = st_q.wake;

    // R7: a rise needs all channels asleep two samples back and the enable
    p_wake_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> ($past(&sleep_i, 2) && $past(wake_en_i)))
        else $error("wake flag rose without a full-sleep exit");

    // R8: a summary read with no possible new event leaves the flag clear
    p_wake_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !wake_en_i) |=> !wake_o)
        else $error("wake flag survived a summary read");
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    parameter int ADDR_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    input  logic [NREG*DATA_W-1:0] regs_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic                   sum_rd_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rp_t;

    rp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en_i) begin
            st_d.data = '0;
            for (int r = 0; r < NREG; r++) begin
                if (rd_addr_i == ADDR_W'(r)) st_d.data = regs_i[r*DATA_W +: DATA_W];
            end
        end
        sum_rd_o = rd_en_i && (rd_addr_i == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data_o = st_q.data;

    // R10: without a strobe the output keeps its value
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o))
        else $error("read data moved without a strobe");
endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH*SRC_N-1:0]   chan_src_i,
    input  logic [NCH*SRC_N-1:0]   chan_en_i,
    input  logic                   tmr_evt_i,
    input  logic                   tmr_en_i,
    input  logic [NCH-1:0]         sleep_i,
    input  logic                   wake_en_i,
    input  logic                   rd_en_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    output logic [DATA_W-1:0]      rd_data_o,
    output logic                   irq_o
);
    localparam int VEC_W = NCH * CODE_W;
    localparam int NLOC  = (VEC_W + DATA_W - 1) / DATA_W;
    localparam int NREG  = NLOC + 1;
    localparam int PAD_W = NLOC * DATA_W - VEC_W;

    typedef struct packed {
        logic [NCH-1:0]   sum;
        logic [VEC_W-1:0] loc;
    } agg_t;

    agg_t                     st_d, st_q;
    logic [CODE_W-1:0]        code_w [NCH];
    logic [NCH-1:0]           req_w;
    logic                     tmr_w;
    logic [NLOC*DATA_W-1:0]   loc_pad_w;
    logic [DATA_W-1:0]        sum_pad_w;
    logic [NREG*DATA_W-1:0]   regs_w;
    logic                     sum_rd_w;
    logic                     wake_w;

    assign tmr_w = tmr_evt_i & tmr_en_i;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        irq_chan_enc #(.HAS_TIMER(n == 0)) u_enc (
            .src_i  (chan_src_i[n*SRC_N +: SRC_N]),
            .en_i   (chan_en_i[n*SRC_N +: SRC_N]),
            .tmr_i  (tmr_w),
            .code_o (code_w[n]),
            .req_o  (req_w[n])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.sum = req_w;
        for (int n = 0; n < NCH; n++) begin
            st_d.loc[n*CODE_W +: CODE_W] = code_w[n];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    if (PAD_W > 0) begin : g_pad
        assign loc_pad_w = {{PAD_W{1'b0}}, st_q.loc};
    end else begin : g_nopad
        assign loc_pad_w = st_q.loc;
    end

    if (DATA_W > NCH) begin : g_spad
        assign sum_pad_w = {{(DATA_W-NCH){1'b0}}, st_q.sum};
    end else begin : g_snopad
        assign sum_pad_w = st_q.sum[DATA_W-1:0];
    end

    assign regs_w = {loc_pad_w, sum_pad_w};

    irq_rd_port #(.DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .regs_i    (regs_w),
        .rd_data_o (rd_data_o),
        .sum_rd_o  (sum_rd_w)
    );

    irq_wake_det #(.NCH(NCH)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_i   (sleep_i),
        .wake_en_i (wake_en_i),
        .clr_i     (sum_rd_w),
        .wake_o    (wake_w)
    );

    assign irq_o = (|st_q.sum) | wake_w;

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        // R2: pending bit and code field agree
        p_sum_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.sum[n] == (st_q.loc[n*CODE_W +: CODE_W] != '0))
            else $error("summary bit and code disagree on channel %0d", n);

        // R4: an enabled line-status request wins on the next cycle
        p_line_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_src_i[n*SRC_N + B_LINE] && chan_en_i[n*SRC_N + B_LINE])
            |=> (st_q.loc[n*CODE_W +: CODE_W] == SRC_LINE))
            else $error("line status not top priority on channel %0d", n);

        if (n > 0) begin : g_notmr
            // R6: code 7 is reserved away from channel 0
            p_no_code7_r6: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.loc[n*CODE_W +: CODE_W] != SRC_TMR)
                else $error("timer code on channel %0d", n);
        end
    end

    // R10: a summary read returns the summary held before the strobe edge
    p_sum_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == '0) |=> (rd_data_o == $past(sum_pad_w)))
        else $error("summary read returned wrong data");
endmodule

// File: tb/irq_gather_bench.sv
`timescale 1ns/1ps
module irq_gather_bench;
    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] chan_src_i = '0;
    logic [31:0] chan_en_i = '0;
    logic        tmr_evt_i = 1'b0;
    logic        tmr_en_i = 1'b0;
    logic [7:0]  sleep_i = '0;
    logic        wake_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    irq_gather u_irq_gather (
        .clk(clk), .rst_n(rst_n), .chan_src_i(chan_src_i), .chan_en_i(chan_en_i),
        .tmr_evt_i(tmr_evt_i), .tmr_en_i(tmr_en_i), .sleep_i(sleep_i),
        .wake_en_i(wake_en_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    // expected code from the requirement text (R4, R5, R6)
    function automatic logic [2:0] exp_code(int ch);
        logic [3:0] a;
        a = chan_src_i[ch*4 +: 4] & chan_en_i[ch*4 +: 4];
        if (a[0]) return 3'd1;
        if (a[1]) return 3'd2;
        if (a[2]) return 3'd3;
        if (a[3]) return 3'd4;
        if (ch == 0 && tmr_evt_i && tmr_en_i) return 3'd7;
        return 3'd0;
    endfunction

    function automatic logic [23:0] exp_vec();
        logic [23:0] v = '0;
        for (int c = 0; c < NCH; c++) v[c*3 +: 3] = exp_code(c);
        return v;
    endfunction

    function automatic logic [7:0] exp_sum();
        logic [7:0] s = '0;
        for (int c = 0; c < NCH; c++) s[c] = (exp_code(c) != 3'd0);
        return s;
    endfunction

    // monitor: compares read data one step after the strobe edge
    always @(posedge clk) begin
        if (rd_en_i) begin
            #1;
            if (exp_q.size() > 0) check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
        end
    end

    task automatic rd_reg(logic [1:0] a, logic [7:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        rd_addr_i = a;
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd_all(string tag);
        logic [23:0] v;
        v = exp_vec();
        rd_reg(2'd0, exp_sum(), {tag, " R2 summary"});
        rd_reg(2'd1, v[7:0],   {tag, " R3 loc0"});
        rd_reg(2'd2, v[15:8],  {tag, " R3 loc1"});
        rd_reg(2'd3, v[23:16], {tag, " R3 loc2"});
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got 0 expected 1 (run ended)");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq after reset", {7'd0, irq_o}, 8'h00);
        check("R1 rdata after reset", rd_data_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd_all("R1 reset");

        // R2/R3: single line-status request on channel 5 -> vector bit 15 (offset 2 bit 7)
        chan_en_i = '1;
        chan_src_i[5*4 + 0] = 1'b1;
        settle();
        rd_reg(2'd0, 8'h20, "R2 ch5 summary");
        rd_reg(2'd2, 8'h80, "R3 ch5 code in offset 2");
        check("R9 irq with channel pending", {7'd0, irq_o}, 8'h01);

        // R10: no strobe -> data holds although registers change
        chan_src_i = '0;
        chan_src_i[1*4 + 3] = 1'b1;
        settle();
        check("R10 hold without strobe", rd_data_o, 8'h80);
        rd_reg(2'd0, 8'h02, "R10 new summary read");

        // R4 ladder on channel 2
        chan_src_i = '0;
        chan_src_i[2*4 +: 4] = 4'b1111;
        settle();
        rd_all("R4 all four");
        chan_src_i[2*4 + 0] = 1'b0; settle(); rd_all("R4 no line");
        chan_src_i[2*4 + 1] = 1'b0; settle(); rd_all("R4 no rx");
        chan_src_i[2*4 + 2] = 1'b0; settle(); rd_all("R4 modem only");
        rd_reg(2'd0, 8'h04, "R4 modem summary fixed");
        rd_reg(2'd2, 8'h01, "R4 modem code 4 at bit 8");

        // R2 clearing when requests drop
        chan_src_i = '0;
        settle();
        rd_reg(2'd0, 8'h00, "R2 cleared");
        check("R9 irq low when idle", {7'd0, irq_o}, 8'h00);

        // R5 disabled request ignored
        chan_en_i = '1;
        chan_en_i[6*4 +: 4] = 4'b0000;
        chan_src_i[6*4 +: 4] = 4'b1111;
        settle();
        rd_reg(2'd0, 8'h00, "R5 disabled summary");
        rd_reg(2'd3, 8'h00, "R5 disabled code");
        chan_en_i[6*4 +: 4] = 4'b0100;
        settle();
        rd_reg(2'd3, 8'h0C, "R5 only tx enabled code 3");
        chan_src_i = '0;
        chan_en_i = '1;

        // R6 timer
        tmr_evt_i = 1'b1;
        tmr_en_i = 1'b0;
        settle();
        rd_reg(2'd0, 8'h00, "R6 timer masked");
        tmr_en_i = 1'b1;
        settle();
        rd_reg(2'd1, 8'h07, "R6 timer code 7 on ch0");
        rd_reg(2'd0, 8'h01, "R6 timer summary ch0");
        chan_src_i[0*4 + 2] = 1'b1;
        settle();
        rd_reg(2'd1, 8'h03, "R6 tx beats timer");
        chan_src_i = '0;
        tmr_evt_i = 1'b0;
        tmr_en_i = 1'b0;

        // R3 mixed pattern across all channels
        chan_src_i = 32'h8421_F312;
        settle();
        rd_all("R3 mixed");
        chan_src_i = '0;
        settle();

        // R7/R8/R9 wake-up
        wake_en_i = 1'b1;
        sleep_i = 8'hFF;
        settle();
        check("R7 no wake while asleep", {7'd0, irq_o}, 8'h00);
        sleep_i[3] = 1'b0;
        settle();
        check("R7 wake after full sleep", {7'd0, irq_o}, 8'h01);
        rd_reg(2'd1, 8'h00, "R8 locator read");
        check("R8 wake kept after locator read", {7'd0, irq_o}, 8'h01);
        rd_reg(2'd0, 8'h00, "R8 summary read");
        check("R8 wake cleared by summary read", {7'd0, irq_o}, 8'h00);

        sleep_i = 8'h7F;
        settle();
        sleep_i = 8'h00;
        settle();
        check("R7 partial sleep no wake", {7'd0, irq_o}, 8'h00);

        wake_en_i = 1'b0;
        sleep_i = 8'hFF;
        settle();
        sleep_i = 8'h00;
        settle();
        check("R7 wake disabled", {7'd0, irq_o}, 8'h00);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule